// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block is a management-bus master for Ethernet PHYs. Software programs a complete Clause 22 transaction by writing one 32-bit command word. The word holds a go flag, the frame type, the opcode, the PHY and register addresses and, for a write, the data. The block then builds the 64-bit frame and shifts it out on MDIO, clocked by an MDC it divides from the system clock. On a read it releases MDIO from turnaround onward and shifts in the 16 data bits the PHY returns.

Completion can be seen in two ways. The go flag reads back as 1 while the frame is on the wire and drops to 0 when it ends. A separate idle flag in the status/configuration word is 1 whenever no frame is running, and it sits next to the captured read value. The same word sets the MDC divider threshold, which edge is used to sample read data, and an input skew compensation of 0 to 7 system clocks. Only one command runs at a time. A command the block cannot run finishes at once and leaves the bus untouched.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command word reads 0x0000_0000, the status word reads idle = 1 with threshold 4, sample edge 0, skew 0 and read data 0, MDC is low and mdio_oe is low.
- R2: The command word is at byte offset 0x0: go = bit 31, type = bit 28 (1 = Clause 22), opcode = bits 27:26 (01 write, 10 read), PHY address = bits 25:21, register address = bits 20:16, write data = bits 15:0. A write with go = 1, type = 1 and a valid opcode starts a frame. Bit 31 reads 1 from the next cycle until the frame ends, then reads 0. Status bit 16 (idle) reads as its inverse.
- R3: The frame leaves MSB first, with each bit changed while MDC is low: 32 ones, 01, the opcode, the PHY address, the register address, turnaround 10 on a write, then 16 data bits (all 64 bits driven on a write).
- R4: On a read, mdio_oe is low for the two turnaround bits and the 16 data bits. The captured bits, MSB first, appear in status bits 15:0 once idle.
- R5: The status word is at offset 0x4 with threshold at bits 31:24. MDC holds each level for T+1 system clocks, where T is the threshold and a threshold of 0 acts as 1. A frame therefore lasts 128·(T+1) clocks.
- R6: Status bit 23 selects the read sampling edge: 0 samples on the MDC rising edge, 1 on the falling edge that ends the bit.
- R7: Status bits 22:20 give a skew S. The value sampled at the selected edge is MDIO as it was S system clocks earlier.
- R8: A write to offset 0x0 while a frame runs has no effect on the stored command or on the frame.
- R9: A go write with type 0, or with opcode 00 or 11, stores the fields but reads idle on the next cycle and never toggles MDC.
- R10: A write to offset 0x4 while a frame runs is ignored.
- R11: Whenever no frame runs, MDC is low and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Byte offset, bit 2 selects the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Drive enable for MDIO |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
On every cycle the assertions check that the bus stays quiet between frames, that every MDC level lasts exactly threshold+1 clocks, that the stored command and configuration hold still while busy, that the master never drives during read turnaround or data, and that valid and invalid go writes start or do not start a frame. Whether the bits on the wire form the right frame, whether the read value is assembled MSB first, and how the sampling edge and skew select which bit is captured can only be shown by the bench scenarios. Those scenarios use a PHY model driving known patterns, including a skew larger than half an MDC period, which shifts the captured word by one bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TURN_POS  = 46;
  localparam int DATA_POS  = 48;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int THR_W     = 8;
  localparam int LAT_W     = 3;
  localparam int DAT_W     = 16;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BAD   = 2'b11
  } mdio_op_e;

  typedef struct packed {
    logic             c22;
    mdio_op_e         op;
    logic [4:0]       phy;
    logic [4:0]       regad;
    logic [DAT_W-1:0] wdata;
  } mdio_cmd_t;

  function automatic logic cmd_runnable(mdio_cmd_t c);
    return c.c22 && ((c.op == OP_WRITE) || (c.op == OP_READ));
  endfunction

  function automatic logic [FRAME_LEN-1:0] frame_bits(mdio_cmd_t c);
    logic [1:0]       turn;
    logic [DAT_W-1:0] payload;
    turn    = (c.op == OP_WRITE) ? 2'b10 : 2'b11;
    payload = (c.op == OP_WRITE) ? c.wdata : {DAT_W{1'b1}};
    return {{PRE_LEN{1'b1}}, 2'b01, c.op, c.phy, c.regad, turn, payload};
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter logic [THR_W-1:0] DEF_THR = 8'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             busy,
  input  logic [DAT_W-1:0] rd_data,
  output logic [31:0]      reg_rdata,
  output mdio_cmd_t        cmd,
  output mdio_cmd_t        launch_cmd,
  output logic             launch,
  output logic [THR_W-1:0] thr,
  output logic             edge_sel,
  output logic [LAT_W-1:0] lat
);
  mdio_cmd_t        cmd_q, cmd_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             edge_q, edge_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             wr_cmd, wr_cfg;
  logic             unused_bits;

  assign unused_bits = ^{reg_wdata[30:29], reg_addr[1:0]};
  assign wr_cmd      = reg_en && reg_we && !reg_addr[2] && !busy;
  assign wr_cfg      = reg_en && reg_we &&  reg_addr[2] && !busy;
  assign launch_cmd  = mdio_cmd_t'(reg_wdata[28:0]);
  assign launch      = wr_cmd && reg_wdata[31] && cmd_runnable(launch_cmd);

  always_comb begin
    cmd_d  = cmd_q;
    thr_d  = thr_q;
    edge_d = edge_q;
    lat_d  = lat_q;
    if (wr_cmd) cmd_d = launch_cmd;
    if (wr_cfg) begin
      thr_d  = reg_wdata[31:24];
      edge_d = reg_wdata[23];
      lat_d  = reg_wdata[22:20];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      thr_q  <= DEF_THR;
      edge_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      cmd_q  <= cmd_d;
      thr_q  <= thr_d;
      edge_q <= edge_d;
      lat_q  <= lat_d;
    end
  end

  assign reg_rdata = reg_addr[2] ? {thr_q, edge_q, lat_q, 3'b000, ~busy, rd_data}
                                 : {busy, 2'b00, cmd_q};
  assign cmd       = cmd_q;
  assign thr       = thr_q;
  assign edge_sel  = edge_q;
  assign lat       = lat_q;
endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [THR_W-1:0] thr,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic [THR_W-1:0] thr_eff;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign thr_eff = (thr == '0) ? THR_W'(1) : thr;
  assign tick    = run && (cnt_q == thr_eff);
  assign rise    = tick && !mdc_q;
  assign fall    = tick &&  mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  mdio_cmd_t        launch_cmd,
  input  logic             rise,
  input  logic             fall,
  input  logic             edge_sel,
  input  logic [LAT_W-1:0] lat,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [DAT_W-1:0] rd_data,
  output logic [BIT_W-1:0] bit_idx,
  output logic             rd_mode
);
  localparam int TAPS = (1 << LAT_W) - 1;

  logic                 busy_q, busy_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic                 rd_q, rd_d;
  logic [DAT_W-1:0]     data_q, data_d;
  logic [TAPS-1:0]      hist_q;
  logic                 rx;
  logic                 sample_now;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q[0] <= 1'b0;
        else        hist_q[0] <= mdio_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q[g] <= 1'b0;
        else        hist_q[g] <= hist_q[g-1];
      end
    end
  end

  assign rx = (lat == '0) ? mdio_i : hist_q[lat - 1'b1];
  assign sample_now = busy_q && rd_q && (bit_q >= BIT_W'(DATA_POS)) &&
                      (edge_sel ? fall : rise);

  always_comb begin
    busy_d = busy_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    data_d = data_q;
    if (sample_now) data_d = {data_q[DAT_W-2:0], rx};
    if (launch) begin
      busy_d = 1'b1;
      bit_d  = '0;
      sh_d   = frame_bits(launch_cmd);
      rd_d   = (launch_cmd.op == OP_READ);
    end else if (busy_q && fall) begin
      if (bit_q == BIT_W'(FRAME_LEN - 1)) begin
        busy_d = 1'b0;
      end else begin
        bit_d = bit_q + 1'b1;
        sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      data_q <= data_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = busy_q && sh_q[FRAME_LEN-1];
  assign mdio_oe = busy_q && !(rd_q && (bit_q >= BIT_W'(TURN_POS)));
  assign rd_data = data_q;
  assign bit_idx = bit_q;
  assign rd_mode = rd_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter logic [THR_W-1:0] DEF_THR = 8'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t        cmd, launch_cmd;
  logic             launch, busy, rise, fall, edge_sel, rd_mode;
  logic [THR_W-1:0] thr;
  logic [LAT_W-1:0] lat;
  logic [DAT_W-1:0] rd_data;
  logic [BIT_W-1:0] bit_idx;

  mdio_regs #(.DEF_THR(DEF_THR)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy), .rd_data(rd_data),
    .reg_rdata(reg_rdata), .cmd(cmd), .launch_cmd(launch_cmd), .launch(launch),
    .thr(thr), .edge_sel(edge_sel), .lat(lat)
  );

  mdio_clk_div u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .thr(thr),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_cmd(launch_cmd),
    .rise(rise), .fall(fall), .edge_sel(edge_sel), .lat(lat), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data),
    .bit_idx(bit_idx), .rd_mode(rd_mode)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_en,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        busy,
  input logic [7:0]  thr,
  input logic        edge_sel,
  input logic [2:0]  lat,
  input logic [28:0] cmd,
  input logic [5:0]  bit_idx,
  input logic        rd_mode
);
  logic       mdc_q;
  logic [9:0] run_len;
  logic [9:0] thr_eff;
  logic       chg, go_wr, op_ok;

  assign thr_eff = (thr == 8'd0) ? 10'd1 : {2'b00, thr};
  assign chg     = (mdc != mdc_q);
  assign go_wr   = reg_en && reg_we && !reg_addr[2] && reg_wdata[31] && !busy;
  assign op_ok   = reg_wdata[28] && ((reg_wdata[27:26] == 2'b01) || (reg_wdata[27:26] == 2'b10));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q   <= 1'b0;
      run_len <= '0;
    end else begin
      mdc_q <= mdc;
      if (!busy)    run_len <= '0;
      else if (chg) run_len <= 10'd1;
      else          run_len <= run_len + 10'd1;
    end
  end

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r5_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chg) |-> (run_len == thr_eff + 10'd1));

  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd));

  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({thr, edge_sel, lat}));

  a_r4_turn_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_mode && (bit_idx >= 6'd46)) |-> !mdio_oe);

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && op_ok) |=> busy);

  a_r9_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !op_ok) |=> !busy);
endmodule

bind mdio_mgmt_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mdc(mdc), .mdio_oe(mdio_oe),
  .busy(busy), .thr(thr), .edge_sel(edge_sel), .lat(lat), .cmd(cmd),
  .bit_idx(bit_idx), .rd_mode(rd_mode)
);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_cmp = 0, n_bad = 0;

  // behavioural reference state
  bit          m_busy = 0, m_mdc = 0, m_read = 0, m_edge = 0, m_c22 = 0;
  int          m_cnt = 0, m_bit = 0;
  logic [63:0] m_frame = '0;
  logic [15:0] m_rd = '0, m_wd = '0;
  logic [7:0]  m_hist = '0, m_thr = 8'd4;
  logic [1:0]  m_op = '0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  logic [2:0]  m_lat = '0;

  logic [15:0] phy_val = 16'h0;
  logic [31:0] last_rd;
  logic [63:0] cap;
  int          capn;
  bit          prev_mdc = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    if (a[2]) return {m_thr, m_edge, m_lat, 3'b000, !m_busy, m_rd};
    return {m_busy, 2'b00, m_c22, m_op, m_phy, m_reg, m_wd};
  endfunction

  task automatic model_step();
    bit   ob;
    int   thr_e;
    logic rx;
    ob    = m_busy;
    thr_e = (m_thr == 0) ? 1 : int'(m_thr);
    if (m_lat == 0) rx = mdio_i;
    else            rx = m_hist[m_lat - 1];
    if (ob) begin
      bit tick, rs, fl;
      tick = (m_cnt == thr_e);
      rs   = tick && !m_mdc;
      fl   = tick && m_mdc;
      if (m_read && m_bit >= 48 && (m_edge ? fl : rs)) m_rd = {m_rd[14:0], rx};
      if (tick) begin
        m_cnt = 0;
        m_mdc = !m_mdc;
        if (fl) begin
          if (m_bit == 63) m_busy = 0;
          else m_bit++;
        end
      end else m_cnt++;
    end
    m_hist = {m_hist[6:0], mdio_i};
    if (reg_en && reg_we && !ob) begin
      if (!reg_addr[2]) begin
        m_c22 = reg_wdata[28]; m_op = reg_wdata[27:26];
        m_phy = reg_wdata[25:21]; m_reg = reg_wdata[20:16]; m_wd = reg_wdata[15:0];
        if (reg_wdata[31] && m_c22 && (m_op == 2'b01 || m_op == 2'b10)) begin
          m_busy = 1; m_cnt = 0; m_mdc = 0; m_bit = 0; m_read = (m_op == 2'b10);
          m_frame = {32'hFFFF_FFFF, 2'b01, m_op, m_phy, m_reg,
                     m_read ? 2'b11 : 2'b10, m_read ? 16'hFFFF : m_wd};
        end
      end else begin
        m_thr = reg_wdata[31:24]; m_edge = reg_wdata[23]; m_lat = reg_wdata[22:20];
      end
    end
  endtask

  // one clock: drive at negedge, advance the model, compare at the next negedge
  task automatic cyc(input logic en, input logic we, input logic [2:0] a, input logic [31:0] d);
    bit oe_exp;
    reg_en = en; reg_we = we; reg_addr = a; reg_wdata = d;
    mdio_i = (m_busy && m_read && m_bit >= 48) ? phy_val[63 - m_bit] : 1'b1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    oe_exp = m_busy && !(m_read && m_bit >= 46);
    check("R5 mdc level", 64'(mdc), 64'(m_mdc));
    check("R4/R11 mdio_oe", 64'(mdio_oe), 64'(oe_exp));
    if (oe_exp) check("R3 mdio_o bit", 64'(mdio_o), 64'(m_frame[63 - m_bit]));
    check("R2 register read", 64'(reg_rdata), 64'(model_rd(a)));
    last_rd = reg_rdata;
    if (mdc && !prev_mdc && mdio_oe) begin
      cap = {cap[62:0], mdio_o};
      capn++;
    end
    prev_mdc = mdc;
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic run_idle(output int n);
    n = 0;
    do begin
      cyc(0, 0, 3'd4, 32'd0);
      n++;
    end while (last_rd[16] == 1'b0 && n < 20000);
  endtask

  function automatic logic [31:0] cmd_word(input bit go, input bit c22, input logic [1:0] op,
                                           input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [15:0] wd);
    return {go, 2'b00, c22, op, phy, rg, wd};
  endfunction

  function automatic logic [31:0] cfg_word(input logic [7:0] t, input bit e, input logic [2:0] l);
    return {t, e, l, 20'h0};
  endfunction

  int n;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 mdc after reset", 64'(mdc), 64'd0);
    check("R1 oe after reset", 64'(mdio_oe), 64'd0);
    cyc(0, 0, 3'd0, 32'd0);
    check("R1 command word", 64'(last_rd), 64'h0);
    cyc(0, 0, 3'd4, 32'd0);
    check("R1 status word", 64'(last_rd), 64'({8'd4, 1'b0, 3'd0, 3'd0, 1'b1, 16'h0}));

    // R2/R3: write frame, threshold 1
    cyc(1, 1, 3'd4, cfg_word(8'd1, 0, 3'd0));
    cap = '0; capn = 0;
    cyc(1, 1, 3'd0, cmd_word(1, 1, 2'b01, 5'd5, 5'h1A, 16'hBEEF));
    cyc(0, 0, 3'd0, 32'd0);
    check("R2 go reads 1 while running", 64'(last_rd[31]), 64'd1);
    run_idle(n);
    check("R3 bits on the wire", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'h1A, 2'b10, 16'hBEEF});
    check("R3 bit count", 64'(capn), 64'd64);
    cyc(0, 0, 3'd0, 32'd0);
    check("R2 go cleared at end", 64'(last_rd[31]), 64'd0);
    check("R11 mdc low when idle", 64'(mdc), 64'd0);

    // R4/R5: read with threshold 0 (acts as 1)
    cyc(1, 1, 3'd4, cfg_word(8'd0, 0, 3'd0));
    phy_val = 16'h9C35;
    cyc(1, 1, 3'd0, cmd_word(1, 1, 2'b10, 5'd3, 5'd2, 16'h0));
    run_idle(n);
    check("R5 frame length threshold 0", 64'(n), 64'd256);
    check("R4 read value", 64'(last_rd[15:0]), 64'h9C35);

    // R6: falling-edge sampling, threshold 3
    cyc(1, 1, 3'd4, cfg_word(8'd3, 1, 3'd0));
    phy_val = 16'hA3C6;
    cyc(1, 1, 3'd0, cmd_word(1, 1, 2'b10, 5'd31, 5'd0, 16'h0));
    run_idle(n);
    check("R5 frame length threshold 3", 64'(n), 64'd512);
    check("R6 falling edge read value", 64'(last_rd[15:0]), 64'hA3C6);

    // R7: skew within the bit
    cyc(1, 1, 3'd4, cfg_word(8'd4, 0, 3'd3));
    phy_val = 16'h5AA5;
    cyc(1, 1, 3'd0, cmd_word(1, 1, 2'b10, 5'd9, 5'd17, 16'h0));
    run_idle(n);
    check("R7 skew 3 read value", 64'(last_rd[15:0]), 64'h5AA5);

    // R7: skew reaching back into the previous bit shifts the word by one
    cyc(1, 1, 3'd4, cfg_word(8'd2, 0, 3'd5));
    cyc(1, 1, 3'd0, cmd_word(1, 1, 2'b10, 5'd9, 5'd17, 16'h0));
    run_idle(n);
    check("R7 skew 5 read value", 64'(last_rd[15:0]), 64'hAD52);

    // R8/R10: writes while running are ignored
    cyc(1, 1, 3'd4, cfg_word(8'd2, 0, 3'd0));
    cyc(1, 1, 3'd0, cmd_word(1, 1, 2'b01, 5'd1, 5'd4, 16'h1234));
    repeat (10) cyc(0, 0, 3'd0, 32'd0);
    cyc(1, 1, 3'd0, cmd_word(1, 1, 2'b10, 5'd7, 5'd7, 16'hFFFF));
    cyc(1, 1, 3'd4, cfg_word(8'd9, 1, 3'd6));
    cyc(0, 0, 3'd0, 32'd0);
    check("R8 command kept while busy", 64'(last_rd), 64'(cmd_word(1, 1, 2'b01, 5'd1, 5'd4, 16'h1234)));
    cyc(0, 0, 3'd4, 32'd0);
    check("R10 config kept while busy", 64'(last_rd[31:20]), 64'({8'd2, 1'b0, 3'd0}));
    run_idle(n);
    check("R8 frame ran to completion", 64'(last_rd[16]), 64'd1);

    // R9: Clause 45 type and reserved opcode do not run
    cyc(1, 1, 3'd0, cmd_word(1, 0, 2'b10, 5'd2, 5'd3, 16'h0));
    cyc(0, 0, 3'd4, 32'd0);
    check("R9 type 0 idle at once", 64'(last_rd[16]), 64'd1);
    cyc(0, 0, 3'd0, 32'd0);
    check("R9 type 0 fields stored", 64'(last_rd), 64'(cmd_word(0, 0, 2'b10, 5'd2, 5'd3, 16'h0)));
    cyc(1, 1, 3'd0, cmd_word(1, 1, 2'b11, 5'd4, 5'd5, 16'h0));
    n = 0;
    for (int k = 0; k < 20; k++) begin
      cyc(0, 0, 3'd0, 32'd0);
      if (mdc) n++;
    end
    check("R9 no MDC for opcode 11", 64'(n), 64'd0);
    check("R9 go not set for opcode 11", 64'(last_rd[31]), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired (R2 completion) actual=busy expected=idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule